// File: doc/BRIEF.md
# Triangle and Noise Wave Generator

This block shapes the data word handed to one converter channel. On each conversion trigger it takes a 12-bit base value and adds an offset to it. The offset is either a triangle ramp, or pseudo-random noise with only its low bits kept. The result is registered and flagged with a one-cycle valid strobe. Each channel uses its own instance, so its mode and amplitude are set on their own.

A 2-bit mode input chooses the offset source. A 4-bit select sets the triangle peak in triangle mode and the width of the noise mask in noise mode. The triangle and noise state advance only on triggers in their own mode. Any change of mode restarts the triangle from zero.

Top module: `wavegen_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `dout` is 0 and `dout_vld` is 0. Reset returns the noise register to 0xAAA and the triangle to 0, counting up.
- R2: `dout_vld` is high in exactly the cycle after a cycle with `trig` high. `dout` changes only in that cycle and holds its value otherwise.
- R3: With `mode` = 2'b00 (off) or 2'b11 (reserved), a trigger loads `dout` with `base` unchanged. Neither the triangle state nor the noise state advances.
- R4: With `mode` = 2'b10 (triangle), each trigger outputs `base` plus the current triangle value and then steps that value by one. The value counts up from 0 to the peak 2^(k+1)-1, where k is `sel`. It then counts down to 0 and repeats, so the outputs run 0,1,...,peak,...,1,0,1,...
- R5: Values of `sel` above 11 act as 11: a peak of 4095, or a mask of all twelve bits.
- R6: With `mode` = 2'b01 (noise), a trigger outputs `base` plus (noise register AND mask). The mask has bits [k:0] set, where k is `sel`. The register then advances once: it shifts left, and the new bit 0 is bit11 ^ bit5 ^ bit3 ^ bit0. Its reset value is 0xAAA.
- R7: The sum of `base` and the offset wraps modulo 4096.
- R8: When `mode` differs from its value in the previous cycle, the triangle returns to 0 and counts up.
- R9: The noise register keeps its value across triggers in any mode other than noise, so noise resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Conversion trigger, one cycle per conversion |
| mode | input | 2 | 00 off, 01 noise, 10 triangle, 11 reserved (off) |
| sel | input | 4 | Triangle peak / noise mask select |
| base | input | 12 | Base value the offset is added to |
| dout | output | 12 | Registered output data |
| dout_vld | output | 1 | High for one cycle when `dout` has been loaded |

## Verification
A triangle counter that runs wrong shows up at the first trigger after the fault. It appears as an output that is not one step away from the last one, or as a turn that comes at the wrong peak. A noise register in the wrong state gives wrong low bits on the next noise trigger. If the register was disturbed during another mode, this shows only once noise mode returns, so the bench checks noise after triangle and off periods. Timing faults in the output register appear as a valid strobe or a data change one cycle off from the trigger.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;
  typedef enum logic [1:0] {
    WM_OFF   = 2'b00,
    WM_NOISE = 2'b01,
    WM_TRI   = 2'b10,
    WM_RSVD  = 2'b11
  } wave_mode_e;
endpackage

// File: rtl/wg_mask_decode.sv
module wg_mask_decode #(
  parameter int DATA_W = 12,
  parameter int SEL_W  = 4
) (
  input  logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] mask
);
  localparam int MAX_SEL = DATA_W - 1;

  logic [SEL_W-1:0] sel_c;
  assign sel_c = (sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign mask[i] = (sel_c >= SEL_W'(i));
  end
endmodule

// File: rtl/wg_triangle.sv
module wg_triangle #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  input  logic [DATA_W-1:0] peak,
  output logic [DATA_W-1:0] value
);
  logic [DATA_W-1:0] cnt;
  logic              going_up;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt      <= '0;
      going_up <= 1'b1;
    end else if (step) begin
      if (going_up) begin
        if (cnt >= peak) begin
          cnt      <= cnt - DATA_W'(1);
          going_up <= 1'b0;
        end else begin
          cnt <= cnt + DATA_W'(1);
        end
      end else begin
        if (cnt == '0) begin
          cnt      <= DATA_W'(1);
          going_up <= 1'b1;
        end else begin
          cnt <= cnt - DATA_W'(1);
        end
      end
    end
  end

  assign value = cnt;
endmodule

// File: rtl/wg_lfsr.sv
module wg_lfsr #(
  parameter int              DATA_W = 12,
  parameter logic [DATA_W-1:0] SEED = 12'hAAA,
  parameter logic [DATA_W-1:0] TAPS = 12'h829
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [DATA_W-1:0] state
);
  logic [DATA_W-1:0] sr;
  logic              fb;

  assign fb = ^(sr & TAPS);

  always_ff @(posedge clk) begin
    if (rst)       sr <= SEED;
    else if (step) sr <= {sr[DATA_W-2:0], fb};
  end

  assign state = sr;
endmodule

// File: rtl/wavegen_top.sv
module wavegen_top #(
  parameter int DATA_W = 12,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [1:0]        mode,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] base,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld
);
  import wavegen_pkg::*;

  wave_mode_e        mode_e, mode_q;
  logic              mode_chg;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] tri_val;
  logic [DATA_W-1:0] lfsr_val;
  logic [DATA_W-1:0] wave;
  logic              tri_step, noise_step;

  assign mode_e     = wave_mode_e'(mode);
  assign mode_chg   = (mode_e != mode_q);
  assign tri_step   = trig && (mode_e == WM_TRI) && !mode_chg;
  assign noise_step = trig && (mode_e == WM_NOISE);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= WM_OFF;
    else     mode_q <= mode_e;
  end

  wg_mask_decode #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_mask (
    .sel  (sel),
    .mask (mask)
  );

  wg_triangle #(.DATA_W(DATA_W)) u_tri (
    .clk   (clk),
    .rst   (rst),
    .clear (mode_chg),
    .step  (tri_step),
    .peak  (mask),
    .value (tri_val)
  );

  wg_lfsr #(.DATA_W(DATA_W)) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .step  (noise_step),
    .state (lfsr_val)
  );

  always_comb begin
    unique case (mode_e)
      WM_NOISE: wave = lfsr_val & mask;
      WM_TRI:   wave = tri_val;
      default:  wave = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= trig;
      if (trig) dout <= base + wave;
    end
  end
endmodule

// File: rtl/wavegen_chk.sv
module wavegen_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              trig,
  input logic [1:0]        mode,
  input logic [DATA_W-1:0] base,
  input logic [DATA_W-1:0] dout,
  input logic              dout_vld,
  input logic [DATA_W-1:0] tri_val,
  input logic [DATA_W-1:0] lfsr_val
);
  // R2
  vld_after_trig_chk: assert property (@(posedge clk) disable iff (rst)
    dout_vld == $past(trig));

  // R2
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !trig |=> $stable(dout));

  // R3
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (trig && (mode == 2'b00 || mode == 2'b11)) |=> (dout == $past(base)));

  // R4
  tri_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tri_val != $past(tri_val)) |->
      (tri_val == $past(tri_val) + DATA_W'(1) ||
       tri_val == $past(tri_val) - DATA_W'(1) ||
       tri_val == '0));

  // R9
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'b01) |=> $stable(lfsr_val));

  // R6
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr_val != '0);
endmodule

bind wavegen_top wavegen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .trig     (trig),
  .mode     (mode),
  .base     (base),
  .dout     (dout),
  .dout_vld (dout_vld),
  .tri_val  (tri_val),
  .lfsr_val (lfsr_val)
);

// File: tb/wavegen_top_tb.sv
module wavegen_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [3:0]  sel = 4'd0;
  logic [11:0] base = 12'd0;
  logic [11:0] dout;
  logic        dout_vld;

  int checks = 0;
  int errors = 0;
  logic [11:0] lfsr_m;

  always #5 clk = ~clk;

  wavegen_top u_dut (
    .clk(clk), .rst(rst), .trig(trig), .mode(mode),
    .sel(sel), .base(base), .dout(dout), .dout_vld(dout_vld)
  );

  typedef struct packed {
    logic [1:0]  m;
    logic [3:0]  s;
    logic [11:0] b;
    logic [11:0] e;
  } vec_t;

  // R3 pass-through, R4 triangle with peak 3, R7 wrap
  localparam vec_t VEC [0:10] = '{
    '{2'b00, 4'd0, 12'h123, 12'h123},
    '{2'b11, 4'd5, 12'h456, 12'h456},
    '{2'b10, 4'd1, 12'd100, 12'd100},
    '{2'b10, 4'd1, 12'd100, 12'd101},
    '{2'b10, 4'd1, 12'd100, 12'd102},
    '{2'b10, 4'd1, 12'd100, 12'd103},
    '{2'b10, 4'd1, 12'd100, 12'd102},
    '{2'b10, 4'd1, 12'd100, 12'd101},
    '{2'b10, 4'd1, 12'd100, 12'd100},
    '{2'b10, 4'd1, 12'hFFE, 12'hFFF},
    '{2'b10, 4'd1, 12'hFFE, 12'h000}
  };

  function automatic logic [11:0] lfsr_next(input logic [11:0] s);
    return {s[10:0], s[11] ^ s[5] ^ s[3] ^ s[0]};
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [1:0] m, input logic [3:0] s, input logic [11:0] b,
                      input logic [11:0] exp, input string req);
    @(negedge clk);
    mode = m; sel = s; base = b;
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    check(req, dout, exp);
    check({req, " vld"}, {11'd0, dout_vld}, 12'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 dout", dout, 12'd0);
    check("R1 vld", {11'd0, dout_vld}, 12'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {dout_vld, dout[10:0]}, 12'd0);

    for (int i = 0; i < 11; i++)
      fire(VEC[i].m, VEC[i].s, VEC[i].b, VEC[i].e, "R3/R4/R7 table");

    // R2: valid drops and data holds with no trigger
    base = 12'h777;
    @(negedge clk);
    check("R2 vld low", {11'd0, dout_vld}, 12'd0);
    check("R2 hold", dout, 12'h000);

    // R6/R5: noise, seed first, full mask via sel above 11
    lfsr_m = 12'hAAA;
    fire(2'b01, 4'd15, 12'd0, lfsr_m, "R6 R5 seed");
    lfsr_m = lfsr_next(lfsr_m);
    fire(2'b01, 4'd12, 12'd0, lfsr_m, "R5 sel12");
    lfsr_m = lfsr_next(lfsr_m);
    fire(2'b01, 4'd2, 12'h010, 12'h010 + (lfsr_m & 12'h007), "R6 mask3");
    lfsr_m = lfsr_next(lfsr_m);
    fire(2'b01, 4'd0, 12'h020, 12'h020 + (lfsr_m & 12'h001), "R6 mask1");
    lfsr_m = lfsr_next(lfsr_m);
    fire(2'b01, 4'd11, 12'hFFF, 12'hFFF + lfsr_m, "R7 noise wrap");
    lfsr_m = lfsr_next(lfsr_m);

    // R8: triangle restarts on entry, peak 1
    fire(2'b10, 4'd0, 12'd50, 12'd50, "R8 R4 restart");
    fire(2'b10, 4'd0, 12'd50, 12'd51, "R4 peak1 up");
    fire(2'b10, 4'd0, 12'd50, 12'd50, "R4 peak1 down");
    fire(2'b10, 4'd3, 12'd50, 12'd51, "R4 up again");
    fire(2'b10, 4'd3, 12'd50, 12'd52, "R4 step");
    fire(2'b00, 4'd3, 12'd9, 12'd9, "R3 off");
    fire(2'b10, 4'd3, 12'd50, 12'd50, "R8 restart after off");

    // R9: noise resumes where it stopped
    fire(2'b01, 4'd11, 12'd0, lfsr_m, "R9 resume");
    lfsr_m = lfsr_next(lfsr_m);
    fire(2'b11, 4'd11, 12'h3C3, 12'h3C3, "R3 reserved");
    fire(2'b01, 4'd11, 12'd0, lfsr_m, "R9 after reserved");

    // R1: reset mid-run reloads the seed
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset", dout, 12'd0);
    rst = 1'b0;
    fire(2'b01, 4'd11, 12'd0, 12'hAAA, "R1 seed reload");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule